// File: doc/BRIEF.md
# Command-queue SPI master

This block is an SPI master that executes a list of transfers held in an on-chip queue, with no processor action per transfer. Software fills the queue through a simple synchronous write/read port. Each queue slot holds a transmit word and a command word. The command word chooses one of four active-low selects, a bit count from 1 to 16 and a gap length in system clocks. Software then programs a first and a last slot and sets the run bit. The sequencer walks the slots in ascending index order, wrapping from 15 to 0. For each slot it runs one mode-0 transfer, most significant bit first, and writes the received bits into that slot's receive word. Software collects results by reading that word like ordinary memory.

With the loop bit clear, one pass ends at the last slot. The run bit then drops and a done flag rises. With the loop bit set, the sequencer returns to the first slot and keeps sampling until software clears the run bit. A cleared run bit is obeyed only at a slot boundary, so the transfer in flight always completes.

Address map (6-bit address, 16-bit data). 0x00–0x0F: transmit words. 0x10–0x1F: command words. 0x20–0x2F: receive words, read-only. 0x30: control. 0x31: half-period divider. 0x32: status, read-only.

Top module: `qseq_spi_top`

## Requirements
- R1: A write to 0x00+i or 0x10+i stores the transmit word or the command word of slot i. A read returns the addressed word on `cpu_rdata` one clock after the address is presented. The command word layout is: bits [1:0] select index, bits [3:2] unused, bits [7:4] bit count minus one, bits [15:8] gap in clocks.
- R2: Control word at 0x30: bit 0 run, bit 1 loop, bits [7:4] first slot, bits [11:8] last slot. Writing it with run set processes the slots from first to last in ascending order, wrapping 15 to 0. Each slot drives low the `cs_n` bit named by its select index, and never more than one bit is low.
- R3: A slot whose count field holds n-1 produces exactly n SCLK rising edges. MOSI carries bits n-1 down to 0 of the transmit word, in that order.
- R4: Mode 0 timing with H = the divider at 0x31 (a value of 0 acts as 1). SCLK is low whenever no select is low. A select falls H clocks before the first rising edge of SCLK and rises H clocks after the last falling edge. SCLK high and low phases each last H clocks, and MOSI changes only while SCLK is low.
- R5: The n bits sampled from MISO on the rising edges are written to the slot's receive word (0x20+i), right-aligned, with the upper bits zero.
- R6: Between two consecutive transfers all selects stay high for exactly gap+4 clocks, where gap is the field of the earlier slot.
- R7: When a pass with loop clear finishes the last slot and its gap, the run bit reads 0. Status bit 0 (done) then reads 1 and status bit 1 (busy) reads 0. Writing the control word with run set clears done.
- R8: With loop set, the slot after the last slot is the first slot again, transfers continue, and done stays 0.
- R9: Clearing the run bit during a transfer lets that transfer complete with its full bit count. No further transfer starts, busy falls and done stays 0.
- R10: After reset all selects are high, SCLK and MOSI are low, and the control and status words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Write strobe for the address map |
| cpu_addr | input | 6 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, one clock after the address |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low peripheral selects |

## Verification
Read data is due one clock after the address, so the bench sets the address just after a falling clock edge and samples at the next falling edge. After a control write the first select falls three clocks later. Select setup and hold each span H clocks, and the gap between transfers spans gap+4 clocks. A monitor samples every falling clock edge and counts these intervals in whole clocks, then compares each count with the value the requirement gives. Status polling starts only a few clocks after the control write, so it does not see the idle state before the sequencer has left it.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  localparam int QW = 16;

  typedef struct packed {
    logic [7:0] gap;
    logic [3:0] nbits_m1;
    logic [1:0] rsvd;
    logic [1:0] sel;
  } qcmd_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_LOAD,
    SQ_XFER,
    SQ_GAP
  } sq_state_t;

  localparam logic [1:0] RG_TX  = 2'd0;
  localparam logic [1:0] RG_CMD = 2'd1;
  localparam logic [1:0] RG_RX  = 2'd2;
  localparam logic [1:0] RG_CTL = 2'd3;
endpackage

// File: rtl/qseq_queue_ram.sv
module qseq_queue_ram #(
  parameter int W     = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          cpu_we_tx,
  input  logic          cpu_we_cmd,
  input  logic [IW-1:0] cpu_idx,
  input  logic [W-1:0]  cpu_wdata,
  output logic [W-1:0]  cpu_tx_q,
  output logic [CW-1:0] cpu_cmd_q,
  output logic [W-1:0]  cpu_rx_q,
  input  logic [IW-1:0] eng_idx,
  output logic [W-1:0]  eng_tx_q,
  output logic [CW-1:0] eng_cmd_q,
  input  logic          eng_rx_we,
  input  logic [W-1:0]  eng_rx_d
);
  logic [W-1:0]  tx_mem  [DEPTH];
  logic [CW-1:0] cmd_mem [DEPTH];
  logic [W-1:0]  rx_mem  [DEPTH];

  // transmit words: written by software, read by both sides
  always_ff @(posedge clk) begin
    if (cpu_we_tx) tx_mem[cpu_idx] <= cpu_wdata;
    cpu_tx_q <= tx_mem[cpu_idx];
    eng_tx_q <= tx_mem[eng_idx];
  end

  // command words: same arrangement
  always_ff @(posedge clk) begin
    if (cpu_we_cmd) cmd_mem[cpu_idx] <= CW'(cpu_wdata);
    cpu_cmd_q <= cmd_mem[cpu_idx];
    eng_cmd_q <= cmd_mem[eng_idx];
  end

  // receive words: written by the engine, read by software
  always_ff @(posedge clk) begin
    if (eng_rx_we) rx_mem[eng_idx] <= eng_rx_d;
    cpu_rx_q <= rx_mem[cpu_idx];
  end
endmodule

// File: rtl/qseq_shift.sv
module qseq_shift #(
  parameter int W    = 16,
  parameter int NCS  = 4,
  parameter int DIVW = 8,
  localparam int LW  = $clog2(W),
  localparam int SW  = $clog2(NCS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [W-1:0]    tx,
  input  logic [LW-1:0]   nbits_m1,
  input  logic [SW-1:0]   sel,
  input  logic [DIVW-1:0] half,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic [W-1:0]    rx,
  output logic            sclk,
  output logic            mosi,
  output logic [NCS-1:0]  cs_n
);
  logic [DIVW-1:0] half_eff, reload, hc_q;
  logic [LW-1:0]   bit_q;
  logic [W-1:0]    sh_q, rx_q;
  logic            busy_q, done_q, ph_q, last_q, sclk_q, mosi_q;
  logic [NCS-1:0]  csn_q;

  assign half_eff = (half == '0) ? DIVW'(1) : half;
  assign reload   = half_eff - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; done_q <= 1'b0; ph_q <= 1'b0; last_q <= 1'b0;
      hc_q <= '0; bit_q <= '0; sh_q <= '0; rx_q <= '0;
      sclk_q <= 1'b0; mosi_q <= 1'b0; csn_q <= '1;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          last_q <= 1'b0;
          ph_q   <= 1'b0;
          hc_q   <= reload;
          bit_q  <= nbits_m1;
          sh_q   <= tx << (LW'(W - 1) - nbits_m1);
          mosi_q <= tx[nbits_m1];
          rx_q   <= '0;
          sclk_q <= 1'b0;
          csn_q  <= ~(NCS'(1) << sel);
        end
      end else if (hc_q != '0) begin
        hc_q <= hc_q - 1'b1;
      end else begin
        hc_q <= reload;
        if (ph_q) begin
          // falling edge: next bit goes out while the clock is low
          sclk_q <= 1'b0;
          ph_q   <= 1'b0;
          if (bit_q == '0) begin
            last_q <= 1'b1;
          end else begin
            bit_q  <= bit_q - 1'b1;
            sh_q   <= sh_q << 1;
            mosi_q <= sh_q[W-2];
          end
        end else if (last_q) begin
          // hold phase after the final falling edge is over
          busy_q <= 1'b0;
          done_q <= 1'b1;
          csn_q  <= '1;
          mosi_q <= 1'b0;
        end else begin
          // rising edge: capture the input bit
          sclk_q <= 1'b1;
          ph_q   <= 1'b1;
          rx_q   <= {rx_q[W-2:0], miso};
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_q;
  assign sclk = sclk_q;
  assign mosi = mosi_q;
  assign cs_n = csn_q;

  a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  a_r4_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
    (&cs_n) |-> !sclk);
  a_r4_data_steady_high: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
  a_r5_done_releases_select: assert property (@(posedge clk) disable iff (rst)
    done |-> (&cs_n));
endmodule

// File: rtl/qseq_seq.sv
module qseq_seq #(
  parameter int DEPTH = 16,
  parameter int GW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          wrap,
  input  logic [IW-1:0] first_idx,
  input  logic [IW-1:0] last_idx,
  input  logic [GW-1:0] gap,
  input  logic          sh_busy,
  input  logic          sh_done,
  output logic [IW-1:0] idx,
  output logic          sh_start,
  output logic          rx_we,
  output logic          busy,
  output logic          pass_end
);
  import qseq_pkg::*;

  sq_state_t     state_q;
  logic [IW-1:0] idx_q;
  logic [GW-1:0] dly_q;
  logic          gap_over;

  assign gap_over = (state_q == SQ_GAP) && (dly_q == '0);
  assign pass_end = gap_over && run && !wrap && (idx_q == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      dly_q   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (run) begin
          idx_q   <= first_idx;
          state_q <= SQ_FETCH;
        end
        SQ_FETCH: state_q <= SQ_LOAD;
        SQ_LOAD: begin
          dly_q   <= gap;
          state_q <= SQ_XFER;
        end
        SQ_XFER: if (sh_done) state_q <= SQ_GAP;
        SQ_GAP: begin
          if (dly_q != '0) begin
            dly_q <= dly_q - 1'b1;
          end else if (!run) begin
            state_q <= SQ_IDLE;
          end else if (idx_q == last_idx) begin
            if (wrap) begin
              idx_q   <= first_idx;
              state_q <= SQ_FETCH;
            end else begin
              state_q <= SQ_IDLE;
            end
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= SQ_FETCH;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign idx      = idx_q;
  assign sh_start = (state_q == SQ_LOAD);
  assign rx_we    = (state_q == SQ_XFER) && sh_done;
  assign busy     = (state_q != SQ_IDLE);

  a_r9_transfer_not_cut: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_XFER && !sh_done) |-> sh_busy);
  a_r2_load_starts_engine: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_LOAD) |=> sh_busy);
  a_r6_gap_is_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_GAP) |-> !sh_busy);
endmodule

// File: rtl/qseq_spi_top.sv
module qseq_spi_top #(
  parameter int DEPTH = 16,
  parameter int NCS   = 4,
  parameter int DIVW  = 8,
  localparam int W    = qseq_pkg::QW,
  localparam int CW   = $bits(qseq_pkg::qcmd_t),
  localparam int IW   = $clog2(DEPTH),
  localparam int AW   = IW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cpu_we,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [W-1:0]   cpu_wdata,
  output logic [W-1:0]   cpu_rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);
  import qseq_pkg::*;

  logic [1:0]      region;
  logic [IW-1:0]   lo;
  logic            run_q, wrap_q, done_q;
  logic [IW-1:0]   first_q, last_q;
  logic [DIVW-1:0] div_q;
  logic [1:0]      region_q;
  logic [W-1:0]    ctl_rd_q, ctl_word;
  logic [W-1:0]    cpu_tx_q, cpu_rx_q, eng_tx_q, sh_rx;
  logic [CW-1:0]   cpu_cmd_q;
  qcmd_t           eng_cmd;
  logic [IW-1:0]   eng_idx;
  logic            sh_start, sh_busy, sh_done, rx_we, seq_busy, pass_end;
  logic            unused_rsvd;

  assign region      = cpu_addr[AW-1 -: 2];
  assign lo          = cpu_addr[IW-1:0];
  assign unused_rsvd = ^eng_cmd.rsvd;

  // control registers; a finished pass overrides a same-cycle write
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; wrap_q <= 1'b0; done_q <= 1'b0;
      first_q <= '0; last_q <= '0; div_q <= '0;
    end else begin
      if (cpu_we && region == RG_CTL) begin
        if (lo == IW'(0)) begin
          run_q   <= cpu_wdata[0];
          wrap_q  <= cpu_wdata[1];
          first_q <= cpu_wdata[4 +: IW];
          last_q  <= cpu_wdata[8 +: IW];
          if (cpu_wdata[0]) done_q <= 1'b0;
        end else if (lo == IW'(1)) begin
          div_q <= cpu_wdata[DIVW-1:0];
        end
      end
      if (pass_end) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl_word = '0;
    if (lo == IW'(0)) begin
      ctl_word[0]         = run_q;
      ctl_word[1]         = wrap_q;
      ctl_word[4 +: IW]   = first_q;
      ctl_word[8 +: IW]   = last_q;
    end else if (lo == IW'(1)) begin
      ctl_word[DIVW-1:0]  = div_q;
    end else if (lo == IW'(2)) begin
      ctl_word[0]         = done_q;
      ctl_word[1]         = seq_busy;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      region_q <= RG_CTL;
      ctl_rd_q <= '0;
    end else begin
      region_q <= region;
      ctl_rd_q <= ctl_word;
    end
  end

  always_comb begin
    unique case (region_q)
      RG_TX:   cpu_rdata = cpu_tx_q;
      RG_CMD:  cpu_rdata = W'(cpu_cmd_q);
      RG_RX:   cpu_rdata = cpu_rx_q;
      default: cpu_rdata = ctl_rd_q;
    endcase
  end

  qseq_queue_ram #(.W(W), .CW(CW), .DEPTH(DEPTH)) queue_i (
    .clk        (clk),
    .cpu_we_tx  (cpu_we && region == RG_TX),
    .cpu_we_cmd (cpu_we && region == RG_CMD),
    .cpu_idx    (lo),
    .cpu_wdata  (cpu_wdata),
    .cpu_tx_q   (cpu_tx_q),
    .cpu_cmd_q  (cpu_cmd_q),
    .cpu_rx_q   (cpu_rx_q),
    .eng_idx    (eng_idx),
    .eng_tx_q   (eng_tx_q),
    .eng_cmd_q  (eng_cmd),
    .eng_rx_we  (rx_we),
    .eng_rx_d   (sh_rx)
  );

  qseq_seq #(.DEPTH(DEPTH), .GW($bits(eng_cmd.gap))) seq_i (
    .clk       (clk),
    .rst       (rst),
    .run       (run_q),
    .wrap      (wrap_q),
    .first_idx (first_q),
    .last_idx  (last_q),
    .gap       (eng_cmd.gap),
    .sh_busy   (sh_busy),
    .sh_done   (sh_done),
    .idx       (eng_idx),
    .sh_start  (sh_start),
    .rx_we     (rx_we),
    .busy      (seq_busy),
    .pass_end  (pass_end)
  );

  qseq_shift #(.W(W), .NCS(NCS), .DIVW(DIVW)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .start    (sh_start),
    .tx       (eng_tx_q),
    .nbits_m1 (eng_cmd.nbits_m1),
    .sel      (eng_cmd.sel),
    .half     (div_q),
    .miso     (miso),
    .busy     (sh_busy),
    .done     (sh_done),
    .rx       (sh_rx),
    .sclk     (sclk),
    .mosi     (mosi),
    .cs_n     (cs_n)
  );

  a_r7_done_means_idle: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !seq_busy);
  a_r7_pass_end_drops_run: assert property (@(posedge clk) disable iff (rst)
    pass_end |=> (!run_q && done_q));
  a_r8_loop_never_done: assert property (@(posedge clk) disable iff (rst)
    (wrap_q && run_q && seq_busy) |-> !pass_end);
endmodule

// File: tb/qseq_spi_top_tb_top.sv
module qseq_spi_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_we = 1'b0;
  logic [5:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  cs_n;

  always #10 clk = ~clk;

  qseq_spi_top dut_i (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // peripheral model: odd selects return the inverse of MOSI, even ones echo it
  always_comb begin
    if (cs_n == 4'hF)                 miso = 1'b0;
    else if (!cs_n[1] || !cs_n[3])    miso = ~mosi;
    else                              miso = mosi;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor, sampled on falling clock edges
  int rec_cs[64], rec_bits[64], rec_word[64], rec_setup[64], rec_hold[64], rec_gap[64];
  int nrec = 0, mode_err = 0, gap_cnt = 0;
  int cur_cs, cur_bits, cur_setup, cur_hold, start_gap;
  logic [15:0] cur_word;
  bit in_xfer = 1'b0, seen_rise = 1'b0;
  logic [3:0] prev_csn = 4'hF;
  logic prev_sclk = 1'b0, prev_mosi = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sclk && cs_n == 4'hF) mode_err++;
      if ($countones(~cs_n) > 1) mode_err++;
      if (sclk && prev_sclk && mosi != prev_mosi) mode_err++;
      if (prev_csn == 4'hF && cs_n != 4'hF) begin
        in_xfer = 1'b1; seen_rise = 1'b0;
        cur_bits = 0; cur_word = '0; cur_setup = 0; cur_hold = 0;
        cur_cs = !cs_n[0] ? 0 : !cs_n[1] ? 1 : !cs_n[2] ? 2 : 3;
        start_gap = gap_cnt;
        if (sclk) mode_err++;
      end
      if (in_xfer && cs_n != 4'hF) begin
        if (sclk && !prev_sclk) begin
          cur_bits++; cur_word = {cur_word[14:0], mosi};
          seen_rise = 1'b1; cur_hold = 0;
        end else if (!sclk) begin
          if (seen_rise) cur_hold++;
          else cur_setup++;
        end
      end
      if (in_xfer && cs_n == 4'hF) begin
        if (nrec < 64) begin
          rec_cs[nrec] = cur_cs; rec_bits[nrec] = cur_bits;
          rec_word[nrec] = int'(cur_word); rec_setup[nrec] = cur_setup;
          rec_hold[nrec] = cur_hold; rec_gap[nrec] = start_gap;
        end
        nrec++;
        in_xfer = 1'b0;
        gap_cnt = 0;
      end
      if (cs_n == 4'hF) gap_cnt++;
      prev_csn = cs_n; prev_sclk = sclk; prev_mosi = mosi;
    end
  end

  task automatic cpu_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); #1;
    cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); #1;
    cpu_addr = a;
    @(negedge clk); #2;
    d = cpu_rdata;
  endtask

  task automatic put_slot(input int i, input logic [15:0] tx, input int sel,
                          input int nbits, input int gap);
    cpu_wr(6'(i), tx);
    cpu_wr(6'(16 + i), {8'(gap), 4'(nbits - 1), 2'b00, 2'(sel)});
  endtask

  task automatic wait_idle();
    logic [15:0] st;
    repeat (6) @(posedge clk);
    for (int k = 0; k < 20000; k++) begin
      cpu_rd(6'h32, st);
      if (!st[1]) break;
    end
  endtask

  function automatic int mask_of(input int n);
    return (n >= 16) ? 32'hFFFF : ((1 << n) - 1);
  endfunction

  function automatic int rx_of(input int tx, input int sel, input int n);
    return ((sel % 2) == 1) ? (~tx & mask_of(n)) : (tx & mask_of(n));
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    chk("R10 cs_n after reset", int'(cs_n), 4'hF);
    chk("R10 sclk after reset", int'(sclk), 0);
    chk("R10 mosi after reset", int'(mosi), 0);
    cpu_rd(6'h30, d); chk("R10 control after reset", int'(d), 0);
    cpu_rd(6'h32, d); chk("R10 status after reset", int'(d), 0);
  endtask

  int p_tx[4]  = '{16'hA5C3, 16'hFFFE, 16'h3C96, 16'h0015};
  int p_sel[4] = '{0, 1, 2, 3};
  int p_n[4]   = '{16, 1, 8, 5};
  int p_gap[4] = '{0, 3, 10, 1};

  task automatic t_regs();
    logic [15:0] d;
    for (int i = 0; i < 4; i++) put_slot(i, 16'(p_tx[i]), p_sel[i], p_n[i], p_gap[i]);
    cpu_rd(6'h02, d); chk("R1 tx word slot 2", int'(d), 16'h3C96);
    cpu_rd(6'h13, d); chk("R1 command word slot 3", int'(d), 16'h0143);
    cpu_rd(6'h10, d); chk("R1 command word slot 0", int'(d), 16'h00F0);
  endtask

  task automatic t_single_pass();
    logic [15:0] d;
    int base = nrec;
    int merr = mode_err;
    cpu_wr(6'h31, 16'd2);
    cpu_wr(6'h30, 16'h0301);
    wait_idle();
    chk("R7 transfer count in one pass", nrec - base, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R2 select order", rec_cs[base + i], p_sel[i]);
      chk("R3 rising edge count", rec_bits[base + i], p_n[i]);
      chk("R3 MOSI word", rec_word[base + i], p_tx[i] & mask_of(p_n[i]));
      chk("R4 select setup clocks", rec_setup[base + i], 2);
      chk("R4 select hold clocks", rec_hold[base + i], 2);
      if (i > 0) chk("R6 gap clocks", rec_gap[base + i], p_gap[i - 1] + 4);
      cpu_rd(6'(32 + i), d);
      chk("R5 receive word", int'(d), rx_of(p_tx[i], p_sel[i], p_n[i]));
    end
    chk("R4 mode 0 shape violations", mode_err - merr, 0);
    cpu_rd(6'h32, d); chk("R7 status done and idle", int'(d), 1);
    cpu_rd(6'h30, d); chk("R7 run bit dropped", int'(d[0]), 0);
  endtask

  int w_idx[4] = '{14, 15, 0, 1};
  int w_tx[4]  = '{16'h000A, 16'h0ABC, 16'h0005, 16'h1234};
  int w_sel[4] = '{1, 2, 3, 0};
  int w_n[4]   = '{4, 12, 3, 16};
  int w_gap[4] = '{2, 0, 5, 3};

  task automatic t_loop_and_stop();
    logic [15:0] d;
    int base, n_stop, k;
    for (int i = 0; i < 4; i++) put_slot(w_idx[i], 16'(w_tx[i]), w_sel[i], w_n[i], w_gap[i]);
    base = nrec;
    cpu_wr(6'h31, 16'd0);
    cpu_wr(6'h30, 16'h01E3);
    for (int t = 0; t < 20000 && nrec < base + 9; t++) @(negedge clk);
    #1;
    chk("R8 transfers keep running in loop", int'(nrec >= base + 9), 1);
    for (int j = 0; j < 9; j++) begin
      chk("R8 loop slot order by select", rec_cs[base + j], w_sel[j % 4]);
      chk("R3 loop edge count", rec_bits[base + j], w_n[j % 4]);
      if (j == 0) chk("R4 divider zero acts as one", rec_setup[base], 1);
      if (j > 0) chk("R6 loop gap clocks", rec_gap[base + j], w_gap[(j + 3) % 4] + 4);
    end
    cpu_rd(6'h32, d); chk("R8 busy and not done while looping", int'(d), 2);
    // R9: clear run in the middle of a transfer
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk); #1;
      if (in_xfer && cur_bits == 1) break;
    end
    n_stop = nrec;
    cpu_wr(6'h30, 16'h01E2);
    wait_idle();
    repeat (40) @(posedge clk);
    @(negedge clk); #1;
    chk("R9 only the running transfer completes", nrec - n_stop, 1);
    k = (n_stop - base) % 4;
    chk("R9 stopped transfer keeps full length", rec_bits[n_stop], w_n[k]);
    cpu_rd(6'h32, d); chk("R9 idle with done clear", int'(d), 0);
    for (int i = 0; i < 4; i++) begin
      cpu_rd(6'(32 + w_idx[i]), d);
      chk("R5 receive word after loop", int'(d), rx_of(w_tx[i], w_sel[i], w_n[i]));
    end
    chk("R4 mode 0 shape violations in loop", mode_err, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    t_reset();
    t_regs();
    t_single_pass();
    t_loop_and_stop();
    finish_run();
  end
endmodule